// File: doc/BRIEF.md
# NAND Reset and Identify Sequencer

This block sits on the host side of a parallel NAND flash link and performs the device bring-up handshake by itself. After a one-cycle start request it resets the device, waits for the ready/busy line to show a complete busy period, asks the device for its identification bytes and judges whether the part is the expected one. The outcome appears as a one-cycle done pulse together with an error flag. The flag stays valid until the next accepted start.

The block drives chip enable, command latch enable, address latch enable, write enable and read enable. It owns the 8-bit bidirectional data bus during write cycles and releases it during read cycles. Strobe widths are set by parameters. The gap between the address write and the first read strobe is set at run time through an input. The expected device code also comes from an input. The maker code is fixed. The first, second and fourth identification bytes are held on output registers for the host to inspect.

Top module: `nand_boot_seq`

## Requirements
- R1: While reset is held, and afterwards until the first start, done and error are 0, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle and nand_ale are 0, and the three identification outputs are 00h.
- R2: A start is accepted only when the block is idle. Its first bus cycle is a command cycle that carries FFh. A start raised while a run is in progress has no effect, so exactly one FFh command appears per run.
- R3: In a write cycle the block drives the byte onto nand_io. It holds nand_cle high (command) or nand_ale high (address) for the whole cycle. It pulls nand_we_n low for WE_LOW clock cycles and then high for WE_HIGH cycles. The device takes the byte on the rising edge of nand_we_n.
- R4: After the FFh command the block waits until the synchronized nand_rb has been seen low and then high. Only then does it issue the identification command.
- R5: If the low-then-high sequence of nand_rb is not completed within BUSY_TIMEOUT clock cycles of entering the wait, the run ends with done and error both high, and no further command, address or read cycle is issued.
- R6: Identification is requested with one command cycle of 90h followed by exactly one address cycle of 00h. A successful run therefore has exactly two command cycles (FFh, 90h) and one address cycle.
- R7: The first nand_re_n falling edge comes exactly WE_HIGH + 1 + turn_cycles clock cycles after the rising edge of nand_we_n that ends the address cycle. turn_cycles must stay stable during a run.
- R8: Exactly five read cycles follow. In each one nand_re_n is low for RE_LOW clock cycles and the byte is sampled in the last low cycle. The block does not drive nand_io while nand_re_n is low.
- R9: The first byte read is compared with ECh and the second with exp_dev. If either differs, error is raised with done. The third and fifth bytes have no effect on error.
- R10: After a successful run, id_maker, id_dev and id_cyc4 hold the first, second and fourth bytes read.
- R11: done is high for exactly one clock cycle at the end of every run, and nand_ce_n is high from that cycle on. error keeps its value until the next accepted start, which clears it.
- R12: nand_cle and nand_ale are never high together. nand_we_n and nand_re_n are never low together. Neither strobe is low while nand_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (taken when idle) |
| exp_dev | input | 8 | Expected device code (second identification byte) |
| turn_cycles | input | TURN_W | Extra wait cycles between the address write and the first read strobe |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Run failed (timeout or identification mismatch); held until next start |
| id_maker | output | 8 | First identification byte captured |
| id_dev | output | 8 | Second identification byte captured |
| id_cyc4 | output | 8 | Fourth identification byte captured |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io | inout | 8 | Bidirectional data bus |
| nand_rb | input | 1 | Ready/busy from the device (low = busy) |

## Verification
The bench builds the block with WE_LOW=2, WE_HIGH=1, RE_LOW=2, RE_HIGH=1, a 3-bit turn_cycles and BUSY_TIMEOUT=64. The narrow turnaround field lets every turnaround value be swept against several busy lengths, each gap checked against WE_HIGH + 1 + turn_cycles. The short timeout puts both stuck-ready and stuck-busy failure paths within a run of about seventy cycles. A device model on the strobes logs every latched byte and serves the identification bytes, so the bench can sweep device codes and vary the don't-care bytes.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_READ_ID = 8'h90;
    localparam logic [7:0] ID_ADDR     = 8'h00;
    localparam logic [7:0] MAKER_CODE  = 8'hEC;

    localparam int ID_LEN    = 5;
    localparam int IDX_MAKER = 0;
    localparam int IDX_DEV   = 1;
    localparam int IDX_CYC4  = 3;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_READ = 2'd2
    } cyc_kind_t;

    typedef struct packed {
        cyc_kind_t  kind;
        logic [7:0] data;
    } bus_req_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_RST     = 4'd1,
        S_BUSY_LO = 4'd2,
        S_BUSY_HI = 4'd3,
        S_ID_CMD  = 4'd4,
        S_ID_ADR  = 4'd5,
        S_TURN    = 4'd6,
        S_READ    = 4'd7,
        S_CHECK   = 4'd8
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic id_good(input logic [7:0] maker,
                                     input logic [7:0] dev,
                                     input logic [7:0] want_dev);
        return (maker == MAKER_CODE) && (dev == want_dev);
    endfunction

endpackage

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_in,
    output logic rb_out
);

    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= rb_in;
            end
            assign rb_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], rb_in};
            end
            assign rb_out = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/nbs_bus_cycle.sv
module nbs_bus_cycle
    import nbs_pkg::*;
#(
    parameter int WR_LO = 2,
    parameter int WR_HI = 2,
    parameter int RD_LO = 2,
    parameter int RD_HI = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  bus_req_t   req,
    input  logic [7:0] din,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic       oe,
    output logic [7:0] dout,
    output logic [7:0] rdata,
    output logic       cyc_done
);

    localparam int MAXPH = imax(imax(WR_LO, WR_HI), imax(RD_LO, RD_HI));
    localparam int CW    = $clog2(MAXPH + 1);
    localparam logic [CW-1:0] WL_LAST = CW'(WR_LO - 1);
    localparam logic [CW-1:0] WH_LAST = CW'(WR_HI - 1);
    localparam logic [CW-1:0] RL_LAST = CW'(RD_LO - 1);
    localparam logic [CW-1:0] RH_LAST = CW'(RD_HI - 1);

    phase_t        ph;
    logic [CW-1:0] cnt;
    bus_req_t      cur;
    logic          is_rd;
    logic          active;

    assign is_rd  = (cur.kind == CYC_READ);
    assign active = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
            rdata <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (go) begin
                        cur <= req;
                        ph  <= PH_LOW;
                        cnt <= (req.kind == CYC_READ) ? RL_LAST : WL_LAST;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        if (is_rd) rdata <= din;
                        ph  <= PH_HIGH;
                        cnt <= is_rd ? RH_LAST : WH_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign we_n     = !((ph == PH_LOW) && !is_rd);
    assign re_n     = !((ph == PH_LOW) && is_rd);
    assign cle      = active && (cur.kind == CYC_CMD);
    assign ale      = active && (cur.kind == CYC_ADDR);
    assign oe       = active && !is_rd;
    assign dout     = cur.data;
    assign cyc_done = (ph == PH_HIGH) && (cnt == '0);

endmodule

// File: rtl/nbs_id_capture.sv
module nbs_id_capture
    import nbs_pkg::*;
#(
    parameter int LEN = ID_LEN,
    localparam int IW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    din,
    output logic [7:0]    maker_o,
    output logic [7:0]    dev_o,
    output logic [7:0]    cyc4_o
);

    logic [LEN-1:0][7:0] held;

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_slot
            if (g == IDX_MAKER || g == IDX_DEV || g == IDX_CYC4) begin : g_keep
                logic [7:0] slot;
                always_ff @(posedge clk) begin
                    if (rst)                        slot <= '0;
                    else if (we && idx == IW'(g))   slot <= din;
                end
                assign held[g] = slot;
            end else begin : g_drop
                assign held[g] = '0;
            end
        end
    endgenerate

    assign maker_o = held[IDX_MAKER];
    assign dev_o   = held[IDX_DEV];
    assign cyc4_o  = held[IDX_CYC4];

endmodule

// File: rtl/nand_boot_seq.sv
module nand_boot_seq
    import nbs_pkg::*;
#(
    parameter int WE_LOW       = 2,
    parameter int WE_HIGH      = 2,
    parameter int RE_LOW       = 2,
    parameter int RE_HIGH      = 2,
    parameter int TURN_W       = 4,
    parameter int BUSY_TIMEOUT = 100000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        exp_dev,
    input  logic [TURN_W-1:0] turn_cycles,
    output logic              done,
    output logic              error,
    output logic [7:0]        id_maker,
    output logic [7:0]        id_dev,
    output logic [7:0]        id_cyc4,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    inout  wire  [7:0]        nand_io,
    input  logic              nand_rb
);

    localparam int TW = $clog2(BUSY_TIMEOUT + 1);
    localparam int IW = $clog2(ID_LEN);
    localparam logic [TW-1:0] TMO_LAST = TW'(BUSY_TIMEOUT - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(ID_LEN - 1);

    seq_state_t        st;
    logic              go_q;
    bus_req_t          req_q;
    logic [TW-1:0]     tmo;
    logic [TURN_W-1:0] tcnt;
    logic [IW-1:0]     idx;
    logic              done_q;
    logic              err_q;

    logic              rb_s;
    logic              bus_oe;
    logic [7:0]        bus_dout;
    logic [7:0]        bus_rdata;
    logic              cyc_done;
    logic              cap_we;

    nbs_rb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rb_sync (
        .clk    (clk),
        .rst    (rst),
        .rb_in  (nand_rb),
        .rb_out (rb_s)
    );

    nbs_bus_cycle #(
        .WR_LO (WE_LOW),
        .WR_HI (WE_HIGH),
        .RD_LO (RE_LOW),
        .RD_HI (RE_HIGH)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .go       (go_q),
        .req      (req_q),
        .din      (nand_io),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .oe       (bus_oe),
        .dout     (bus_dout),
        .rdata    (bus_rdata),
        .cyc_done (cyc_done)
    );

    assign cap_we = (st == S_READ) && cyc_done;

    nbs_id_capture #(
        .LEN (ID_LEN)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .we      (cap_we),
        .idx     (idx),
        .din     (bus_rdata),
        .maker_o (id_maker),
        .dev_o   (id_dev),
        .cyc4_o  (id_cyc4)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            go_q   <= 1'b0;
            req_q  <= '0;
            tmo    <= '0;
            tcnt   <= '0;
            idx    <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        err_q <= 1'b0;
                        st    <= S_RST;
                        go_q  <= 1'b1;
                        req_q <= '{kind: CYC_CMD, data: CMD_RESET};
                    end
                end
                S_RST: begin
                    if (cyc_done) begin
                        st  <= S_BUSY_LO;
                        tmo <= '0;
                    end
                end
                S_BUSY_LO: begin
                    if (!rb_s) begin
                        st  <= S_BUSY_HI;
                        tmo <= tmo + 1'b1;
                    end else if (tmo >= TMO_LAST) begin
                        st     <= S_IDLE;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                S_BUSY_HI: begin
                    if (rb_s) begin
                        st    <= S_ID_CMD;
                        go_q  <= 1'b1;
                        req_q <= '{kind: CYC_CMD, data: CMD_READ_ID};
                    end else if (tmo >= TMO_LAST) begin
                        st     <= S_IDLE;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                S_ID_CMD: begin
                    if (cyc_done) begin
                        st    <= S_ID_ADR;
                        go_q  <= 1'b1;
                        req_q <= '{kind: CYC_ADDR, data: ID_ADDR};
                    end
                end
                S_ID_ADR: begin
                    if (cyc_done) begin
                        idx   <= '0;
                        req_q <= '{kind: CYC_READ, data: 8'h00};
                        if (turn_cycles == '0) begin
                            st   <= S_READ;
                            go_q <= 1'b1;
                        end else begin
                            st   <= S_TURN;
                            tcnt <= turn_cycles;
                        end
                    end
                end
                S_TURN: begin
                    if (tcnt == TURN_W'(1)) begin
                        st   <= S_READ;
                        go_q <= 1'b1;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                S_READ: begin
                    if (cyc_done) begin
                        if (idx == IDX_LAST) begin
                            st <= S_CHECK;
                        end else begin
                            idx  <= idx + 1'b1;
                            go_q <= 1'b1;
                        end
                    end
                end
                S_CHECK: begin
                    st     <= S_IDLE;
                    done_q <= 1'b1;
                    err_q  <= !id_good(id_maker, id_dev, exp_dev);
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign nand_io   = bus_oe ? bus_dout : 8'bz;
    assign nand_ce_n = (st == S_IDLE);
    assign done      = done_q;
    assign error     = err_q;

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic io_oe,
    input logic done,
    input logic error
);

    assert_cle_ale_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_we_re_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_strobe_needs_ce_R12: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n);

    assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!cle && !ale && !io_oe));

    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !io_oe);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_error_rises_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

    assert_error_held_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !start) |=> $stable(error));

endmodule

bind nand_boot_seq nbs_checker u_nbs_checker (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ce_n  (nand_ce_n),
    .cle   (nand_cle),
    .ale   (nand_ale),
    .we_n  (nand_we_n),
    .re_n  (nand_re_n),
    .io_oe (bus_oe),
    .done  (done),
    .error (error)
);

// File: tb/test_nand_boot_seq.sv
`timescale 1ns/1ps
module test_nand_boot_seq;

    localparam int P_WE_LOW  = 2;
    localparam int P_WE_HIGH = 1;
    localparam int P_RE_LOW  = 2;
    localparam int P_RE_HIGH = 1;
    localparam int P_TURN_W  = 3;
    localparam int P_TMO     = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] exp_dev = 8'h00;
    logic [P_TURN_W-1:0] turn = '0;
    logic done, error;
    logic [7:0] id_maker, id_dev, id_cyc4;
    logic ce_n, cle, ale, we_n, re_n;
    logic rb = 1'b1;
    wire  [7:0] nand_io;

    always #2.5 clk = ~clk;

    nand_boot_seq #(
        .WE_LOW       (P_WE_LOW),
        .WE_HIGH      (P_WE_HIGH),
        .RE_LOW       (P_RE_LOW),
        .RE_HIGH      (P_RE_HIGH),
        .TURN_W       (P_TURN_W),
        .BUSY_TIMEOUT (P_TMO),
        .SYNC_STAGES  (2)
    ) i_nand_boot_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .exp_dev     (exp_dev),
        .turn_cycles (turn),
        .done        (done),
        .error       (error),
        .id_maker    (id_maker),
        .id_dev      (id_dev),
        .id_cyc4     (id_cyc4),
        .nand_ce_n   (ce_n),
        .nand_cle    (cle),
        .nand_ale    (ale),
        .nand_we_n   (we_n),
        .nand_re_n   (re_n),
        .nand_io     (nand_io),
        .nand_rb     (rb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] rom [5];
    int cyc = 0;
    int cmd_n, addr_n, rd_n, ff_n, id_n, rd_idx;
    logic [7:0] last_addr;
    int addr_rise_cyc, first_re_cyc, id_cmd_cyc, rb_rise_cyc;
    int we_fall_cyc, we_lo_len, re_fall_cyc, re_lo_len;
    bit want_first;
    int rb_mode, busy_len, rb_ctr;
    bit rst_flag, rb_act, rb_restore;

    always @(posedge clk) cyc++;

    assign nand_io = (!re_n && !ce_n) ? ((rd_idx < 5) ? rom[rd_idx] : 8'h00) : 8'hzz;

    always @(negedge we_n) we_fall_cyc = cyc;

    always @(posedge we_n) begin
        if (ce_n === 1'b0) begin
            if (cle) begin
                cmd_n++;
                if (nand_io == 8'hFF) begin
                    ff_n++;
                    rst_flag = 1'b1;
                    we_lo_len = cyc - we_fall_cyc;
                end
                if (nand_io == 8'h90) begin
                    id_n++;
                    id_cmd_cyc = cyc;
                    rd_idx = 0;
                end
            end
            if (ale) begin
                addr_n++;
                last_addr = nand_io;
                addr_rise_cyc = cyc;
                want_first = 1'b1;
            end
        end
    end

    always @(negedge re_n) begin
        re_fall_cyc = cyc;
        if (want_first) begin
            first_re_cyc = cyc;
            want_first = 1'b0;
        end
    end

    always @(posedge re_n) begin
        if (ce_n === 1'b0) begin
            rd_n++;
            rd_idx++;
            re_lo_len = cyc - re_fall_cyc;
        end
    end

    // ready/busy: mode 0 normal, 1 never goes low, 2 never returns high
    always @(negedge clk) begin
        if (rb_restore) begin
            rb = 1'b1;
            rb_act = 1'b0;
            rb_restore = 1'b0;
        end
        if (rst_flag) begin
            rst_flag = 1'b0;
            rb_ctr = 0;
            rb_act = 1'b1;
        end
        if (rb_act) begin
            rb_ctr++;
            if (rb_mode != 1 && rb_ctr == 2) rb = 1'b0;
            if (rb_mode == 0 && rb_ctr == 2 + busy_len) begin
                rb = 1'b1;
                rb_rise_cyc = cyc;
                rb_act = 1'b0;
            end
        end
    end

    task automatic do_run(input int mode, input int blen,
                          input logic [7:0] mk, input logic [7:0] dv,
                          input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5,
                          input logic [7:0] xdev, input int t,
                          input bit extra, input bit exp_err);
        int waited;
        bit seen;
        rom[0] = mk; rom[1] = dv; rom[2] = b3; rom[3] = b4; rom[4] = b5;
        rb_mode = mode; busy_len = blen; rb_restore = 1'b1;
        cmd_n = 0; addr_n = 0; rd_n = 0; ff_n = 0; id_n = 0; rd_idx = 0;
        last_addr = 8'hA5; addr_rise_cyc = 0; first_re_cyc = 0;
        id_cmd_cyc = 0; rb_rise_cyc = 0; we_lo_len = 0; re_lo_len = 0;
        want_first = 1'b0;
        exp_dev = xdev;
        turn = P_TURN_W'(t);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 error cleared by accepted start", {31'd0, error}, 32'd0);
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 3000) begin
            @(negedge clk);
            waited++;
            start = (extra && waited == 6);
            if (done) seen = 1'b1;
        end
        start = 1'b0;
        if (!seen) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 run watchdog actual=no_done expected=done");
            return;
        end
        chk(exp_err ? "R9/R5 error expected" : "R9 error clear on match", {31'd0, error}, {31'd0, exp_err});
        @(negedge clk);
        chk("R11 done single cycle", {31'd0, done}, 32'd0);
        chk("R11 ce_n high after done", {31'd0, ce_n}, 32'd1);
        chk("R2 one reset command per run", ff_n, 1);
        chk("R3 write low width", we_lo_len, P_WE_LOW);
        if (mode == 0) begin
            chk("R6 command count", cmd_n, 2);
            chk("R6 address count", addr_n, 1);
            chk("R6 address byte", {24'd0, last_addr}, 32'h00);
            chk("R4 id command after ready", {31'd0, (id_cmd_cyc > rb_rise_cyc)}, 32'd1);
            chk("R8 read count", rd_n, 5);
            chk("R8 read low width", re_lo_len, P_RE_LOW);
            chk("R7 turnaround gap", first_re_cyc - addr_rise_cyc, P_WE_HIGH + 1 + t);
            chk("R10 maker byte", {24'd0, id_maker}, {24'd0, mk});
            chk("R10 device byte", {24'd0, id_dev}, {24'd0, dv});
            chk("R10 fourth byte", {24'd0, id_cyc4}, {24'd0, b4});
        end else begin
            chk("R5 no id command on timeout", cmd_n, 1);
            chk("R5 no address on timeout", addr_n, 0);
            chk("R5 no reads on timeout", rd_n, 0);
        end
        if (exp_err) begin
            repeat (10) @(negedge clk);
            chk("R11 error held while idle", {31'd0, error}, 32'd1);
        end
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL R11 global watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rb_mode = 0; busy_len = 1; rb_restore = 1'b0; rst_flag = 1'b0; rb_act = 1'b0; rb_ctr = 0;
        rd_idx = 0;
        for (int i = 0; i < 5; i++) rom[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        chk("R1 ce_n in reset", {31'd0, ce_n}, 32'd1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 error after reset", {31'd0, error}, 32'd0);
        chk("R1 we_n idle", {31'd0, we_n}, 32'd1);
        chk("R1 re_n idle", {31'd0, re_n}, 32'd1);
        chk("R1 cle idle", {31'd0, cle}, 32'd0);
        chk("R1 ale idle", {31'd0, ale}, 32'd0);
        chk("R1 id outputs cleared", {8'd0, id_maker, id_dev, id_cyc4}, 32'd0);

        // R7 sweep of every turnaround value against several busy lengths
        for (int t = 0; t < 8; t++) begin
            for (int k = 0; k < 3; k++) begin
                int bl;
                bl = (k == 0) ? 1 : ((k == 1) ? 5 : 20);
                do_run(0, bl, 8'hEC, 8'hDA, 8'(t * 17), 8'(8'h15 + t), 8'(8'h44 ^ t),
                       8'hDA, t, 1'b0, 1'b0);
            end
        end

        // R9 device code sweep: match, then single-bit mismatch
        for (int d = 0; d < 8; d++) begin
            logic [7:0] code;
            code = 8'(d * 37 + 3);
            do_run(0, 3, 8'hEC, code, 8'hFF, 8'h55, 8'h00, code, d, 1'b0, 1'b0);
            do_run(0, 3, 8'hEC, code, 8'h00, 8'h55, 8'h44, code ^ 8'(1 << d), d, 1'b0, 1'b1);
        end

        // R9 maker mismatch
        do_run(0, 4, 8'hEB, 8'hDA, 8'h00, 8'h15, 8'h44, 8'hDA, 2, 1'b0, 1'b1);
        do_run(0, 4, 8'h6C, 8'hDA, 8'h00, 8'h15, 8'h44, 8'hDA, 0, 1'b0, 1'b1);

        // R5 ready/busy never goes low, then never returns high
        do_run(1, 0, 8'hEC, 8'hDA, 8'h00, 8'h15, 8'h44, 8'hDA, 1, 1'b0, 1'b1);
        do_run(2, 0, 8'hEC, 8'hDA, 8'h00, 8'h15, 8'h44, 8'hDA, 1, 1'b0, 1'b1);

        // R2 start raised mid-run is ignored; recovery after timeout
        do_run(0, 6, 8'hEC, 8'hAA, 8'h12, 8'h15, 8'h44, 8'hAA, 3, 1'b1, 1'b0);
        do_run(0, 2, 8'hEC, 8'hBA, 8'h34, 8'h55, 8'h44, 8'hBA, 7, 1'b1, 1'b0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule